// File: doc/BRIEF.md
# Opcode-Decoded Byte Shifter and Rotator

This combinational unit sits in the execute stage of a small 8-bit processor. It takes a data byte, a 3-bit distance and a 6-bit operation code. It returns the byte shifted or rotated left or right by that distance. Right shifts are filled either with zeros or with copies of the sign bit. A valid flag tells the surrounding logic whether the operation code belongs to the shift/rotate family.

The work is split between two modules. A decoder turns the operation code into a small set of strobes: direction, rotate, sign fill and valid. A datapath acts on those strobes. The datapath holds one right-acting logarithmic network made of three stages of 2:1 multiplexers, which move the data by 4, then by 2, then by 1 position. A fill multiplexer sits ahead of that network. Left operations reuse the same network: the byte is mirrored before the network and mirrored again after it.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 110000 shifts the byte right by the distance and fills the vacated upper bits with 0 (11000001 by 4 gives 00001100).
- R2: Operation code 110001 shifts right and fills the vacated upper bits with the byte's bit 7 (11000001 by 4 gives 11111100).
- R3: Operation codes 110010 and 110011 rotate the byte right. Bits leaving bit 0 re-enter at bit 7, and the code's bit 0 has no effect on the result.
- R4: Operation code 110100 shifts left and fills the vacated lower bits with 0.
- R5: Operation code 110101 gives exactly the result of code 110100 for every byte and distance, including bytes with bit 7 set.
- R6: Operation codes 110110 and 110111 rotate the byte left. Bits leaving bit 7 re-enter at bit 0, and the code's bit 0 has no effect on the result.
- R7: With distance 0, every recognised code returns the byte unchanged.
- R8: Any code whose upper three bits are not 110 returns the byte unchanged with valid at 0. Every code with upper bits 110 sets valid to 1.
- R9: Distance bit 2 moves the data by 4 places, bit 1 by 2 and bit 0 by 1, and the moves add up, so all distances 0 to 7 are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | 8 | Byte to be shifted or rotated |
| shiftAmt | input | 3 | Distance, 0 to 7 |
| opCode | input | 6 | Shift/rotate operation code |
| dataOut | output | 8 | Result byte |
| opValid | output | 1 | 1 when the operation code is recognised |

## Verification
The mirroring used for left operations and the sign-fill selection act in the same evaluation. An arithmetic-left code applied to a byte with bit 7 set therefore exercises both at once. If the fill choice ignores direction, sign copies appear in the low bits after the second mirror. The bench provokes this by sweeping code 110101 over negative bytes at every distance. It judges each result against a reference computed independently for a left shift with zero fill. Rotates at distance 4 are also compared across both values of the don't-care bit.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;
  localparam int DATA_W = 8;
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int OP_W   = 6;
  localparam logic [2:0] FAMILY_TAG = 3'b110;

  typedef struct packed {
    logic valid;
    logic goLeft;
    logic rotate;
    logic signFill;
  } shiftStrobes_t;
endpackage

// File: rtl/shift_rotate_ctrl.sv
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] opCode,
  output shiftStrobes_t  strobes
);
  localparam int TAG_LO = OPW - 3;

  logic inFamily;

  always_comb begin
    inFamily = (opCode[OPW-1:TAG_LO] == FAMILY_TAG);
    strobes  = '0;
    if (inFamily) begin
      strobes.valid    = 1'b1;
      strobes.goLeft   = opCode[2];
      strobes.rotate   = opCode[1];
      strobes.signFill = opCode[0] & ~opCode[1] & ~opCode[2];
    end
  end

  always_comb begin
    if (!$isunknown(opCode)) begin
      assert_invalid_quiet_R8: assert (strobes.valid || strobes == '0)
        else $error("strobes active for unrecognised code");
      assert_sign_only_right_R5: assert (!(strobes.signFill && strobes.goLeft))
        else $error("sign fill requested on a left shift");
    end
  end
endmodule

// File: rtl/shift_rotate_datapath.sv
module shift_rotate_datapath
  import shift_rotate_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = AMT_W
) (
  input  logic [W-1:0]  dataIn,
  input  logic [AW-1:0] shiftAmt,
  input  shiftStrobes_t strobes,
  output logic [W-1:0]  dataOut
);
  localparam int STAGES = AW;

  logic [W-1:0] mirrorIn;
  logic [W-1:0] netIn;
  logic [W-1:0] netOut;
  logic [W-1:0] mirrorOut;
  logic [W-1:0] stageVal [0:STAGES];
  logic         fillBit;

  // mirror the byte for left operations
  generate
    for (genvar i = 0; i < W; i++) begin : g_mirror
      assign mirrorIn[i]  = dataIn[W-1-i];
      assign mirrorOut[i] = netOut[W-1-i];
    end
  endgenerate

  assign netIn       = strobes.goLeft ? mirrorIn : dataIn;
  assign fillBit     = strobes.signFill ? dataIn[W-1] : 1'b0;
  assign stageVal[0] = netIn;

  // right-acting network, largest step first
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int STEP = 2 ** (STAGES - 1 - s);
      logic stageSel;
      assign stageSel = shiftAmt[STAGES-1-s];
      for (genvar i = 0; i < W; i++) begin : g_bit
        if (i + STEP < W) begin : g_inner
          assign stageVal[s+1][i] = stageSel ? stageVal[s][i+STEP] : stageVal[s][i];
        end else begin : g_edge
          assign stageVal[s+1][i] = stageSel
            ? (strobes.rotate ? stageVal[s][i+STEP-W] : fillBit)
            : stageVal[s][i];
        end
      end
    end
  endgenerate

  assign netOut = stageVal[STAGES];

  always_comb begin
    if (!strobes.valid)     dataOut = dataIn;
    else if (strobes.goLeft) dataOut = mirrorOut;
    else                     dataOut = netOut;
  end

  always_comb begin
    if (!$isunknown({dataIn, shiftAmt, strobes})) begin
      assert_zero_pass_R7: assert (!(strobes.valid && shiftAmt == '0) || dataOut == dataIn)
        else $error("distance 0 altered the byte");
      assert_invalid_pass_R8: assert (strobes.valid || dataOut == dataIn)
        else $error("unrecognised code altered the byte");
      assert_rotate_keeps_ones_R3: assert (!(strobes.valid && strobes.rotate)
          || $countones(dataOut) == $countones(dataIn))
        else $error("rotate lost or gained ones");
      assert_sign_fill_R2: assert (!(strobes.valid && strobes.signFill)
          || dataOut[W-1] == dataIn[W-1])
        else $error("arithmetic right lost the sign");
      assert_zero_fill_right_R1: assert (!(strobes.valid && !strobes.rotate
          && !strobes.goLeft && !strobes.signFill && shiftAmt != '0) || !dataOut[W-1])
        else $error("logical right left a one on top");
      assert_zero_fill_left_R4: assert (!(strobes.valid && !strobes.rotate
          && strobes.goLeft && shiftAmt != '0) || !dataOut[0])
        else $error("left shift left a one at bottom");
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [OP_W-1:0]   opCode,
  output logic [DATA_W-1:0] dataOut,
  output logic              opValid
);
  shiftStrobes_t strobes;

  shift_rotate_ctrl #(.OPW(OP_W)) ctrl_i (
    .opCode (opCode),
    .strobes(strobes)
  );

  shift_rotate_datapath #(.W(DATA_W), .AW(AMT_W)) dp_i (
    .dataIn  (dataIn),
    .shiftAmt(shiftAmt),
    .strobes (strobes),
    .dataOut (dataOut)
  );

  assign opValid = strobes.valid;
endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] dataIn = '0;
  logic [2:0] shiftAmt = '0;
  logic [5:0] opCode = '0;
  logic [7:0] dataOut;
  logic       opValid;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rotate_unit dut_i (
    .dataIn(dataIn), .shiftAmt(shiftAmt), .opCode(opCode),
    .dataOut(dataOut), .opValid(opValid)
  );

  // independent reference: dir 0 right, 1 left; kind 0 zero fill, 1 sign fill, 2 rotate
  function automatic logic [7:0] refModel(input logic [7:0] x, input int amt,
                                          input bit dir, input int kind);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (!dir) begin
        if (i + amt < 8) r[i] = x[i+amt];
        else if (kind == 2) r[i] = x[i+amt-8];
        else if (kind == 1) r[i] = x[7];
        else r[i] = 1'b0;
      end else begin
        if (i - amt >= 0) r[i] = x[i-amt];
        else if (kind == 2) r[i] = x[i-amt+8];
        else r[i] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic apply(input logic [7:0] d, input int a, input logic [5:0] op);
    @(negedge clk);
    dataIn = d; shiftAmt = a[2:0]; opCode = op;
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] exp, input logic expV);
    checks++;
    if (dataOut !== exp || opValid !== expV) begin
      fails++;
      $display("FAIL %s: op=%b d=%b amt=%0d got %b/%b expected %b/%b",
               req, opCode, dataIn, shiftAmt, dataOut, opValid, exp, expV);
    end
  endtask

  task automatic sweep(input string req, input logic [5:0] op, input bit dir, input int kind);
    logic [7:0] pats [6] = '{8'hC1, 8'h87, 8'h3C, 8'h80, 8'h01, 8'hA5};
    foreach (pats[p])
      for (int a = 0; a < 8; a++) begin
        apply(pats[p], a, op);
        check(req, refModel(pats[p], a, dir, kind), 1'b1);
      end
  endtask

  task automatic testResetState();
    apply(8'h5A, 0, 6'b000000);
    check("R8 idle", 8'h5A, 1'b0);
  endtask

  task automatic testKnownVectors();
    apply(8'b11000001, 4, 6'b110000); check("R1", 8'b00001100, 1'b1);
    apply(8'b11000001, 4, 6'b110001); check("R2", 8'b11111100, 1'b1);
    apply(8'b11000000, 4, 6'b110010); check("R3", 8'b00001100, 1'b1);
    apply(8'b10000111, 3, 6'b110011); check("R3", 8'b11110000, 1'b1);
    apply(8'b10000111, 3, 6'b110000); check("R1", 8'b00010000, 1'b1);
  endtask

  task automatic testSweeps();
    sweep("R1", 6'b110000, 0, 0);
    sweep("R2", 6'b110001, 0, 1);
    sweep("R3", 6'b110010, 0, 2);
    sweep("R3", 6'b110011, 0, 2);
    sweep("R4", 6'b110100, 1, 0);
    sweep("R5", 6'b110101, 1, 0);
    sweep("R6", 6'b110110, 1, 2);
    sweep("R6", 6'b110111, 1, 2);
  endtask

  task automatic testZeroDistance();
    for (int op = 48; op < 56; op++) begin
      apply(8'hD3, 0, op[5:0]);
      check("R7", 8'hD3, 1'b1);
    end
  endtask

  task automatic testInvalid();
    for (int op = 0; op < 64; op++) begin
      if (op[5:3] != 3'b110) begin
        apply(8'h96, 5, op[5:0]);
        check("R8", 8'h96, 1'b0);
      end
    end
  endtask

  task automatic testStages();
    // single 1 at bit 7 moved right by each power, then combined
    apply(8'h80, 4, 6'b110000); check("R9", 8'h08, 1'b1);
    apply(8'h80, 2, 6'b110000); check("R9", 8'h20, 1'b1);
    apply(8'h80, 1, 6'b110000); check("R9", 8'h40, 1'b1);
    apply(8'h80, 7, 6'b110000); check("R9", 8'h01, 1'b1);
    apply(8'h01, 6, 6'b110100); check("R9", 8'h40, 1'b1);
  endtask

  initial begin
    testResetState();
    testKnownVectors();
    testSweeps();
    testZeroDistance();
    testInvalid();
    testStages();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule